// File: doc/BRIEF.md
# Round-Robin Warp Scheduler

This block chooses, once per cycle, which warp is handed to instruction fetch. It searches the warps in a rotating order that starts just after the warp it chose last and takes the first one that is both active and not held back by a pending stall. When nothing qualifies, it presents no choice for that cycle and remembers where it stopped.

Each warp has one stall bit inside the block. A fetch-side event sets that bit for a named warp when a fetched instruction must block its warp. A writeback-side event clears it when that instruction retires. The active mask comes from outside the block, and the consumer applies back-pressure through a ready input. The choice is registered and stays fixed while the consumer is not ready.

Top module: `warp_rr_sched`

## Requirements
- R1: After reset `pickValid` is 0, every stall bit is clear, and the first search starts at warp 0. With only warp 0 active, the first cycle after reset yields `pickValid`=1 and `pickWid`=0.
- R2: Each search starts at (previous pick + 1) modulo `NUM_WARPS` and wraps once over all warps. With all warps eligible, the picks run 0,1,2,3,0 for four warps.
- R3: A warp may be picked only if its bit in `activeMask` is 1 and its stall bit is 0. Ineligible warps are skipped in the rotation.
- R4: If no warp is eligible when the scheduler advances, `pickValid` goes to 0 and `pickWid` keeps the last pick. The next search starts after that retained warp.
- R5: `stallSetValid` with `stallSetWid` sets that warp's stall bit at the clock edge. The warp is excluded from searches in later cycles, but not from the search at that same edge.
- R6: `stallClrValid` with `stallClrWid` clears that warp's stall bit at the clock edge. The warp becomes eligible again from the next search.
- R7: If a set and a clear name the same warp in one cycle, the stall bit ends up clear.
- R8: While `pickValid` is 1 and `fetchReady` is 0, `pickValid` and `pickWid` hold their values whatever the other inputs do.
- R9: The choice is registered. A new pick appears on the outputs one clock edge after the cycle in which the scheduler advances, which is any cycle with `pickValid`=0 or `fetchReady`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| activeMask | input | NUM_WARPS | One bit per warp, 1 = warp is active |
| stallSetValid | input | 1 | Fetched instruction blocks its warp |
| stallSetWid | input | WID_W | Warp whose stall bit is set |
| stallClrValid | input | 1 | Blocking instruction reached writeback |
| stallClrWid | input | WID_W | Warp whose stall bit is cleared |
| fetchReady | input | 1 | Consumer accepts the current pick |
| pickValid | output | 1 | A warp is being offered |
| pickWid | output | WID_W | Offered warp, or the last pick when not valid |

## Verification
The assertions take two things for granted. Warp IDs on the set and clear inputs are below `NUM_WARPS`. `activeMask` is a stable level during each cycle. The bench changes inputs only on the falling edge and uses only legal warp IDs for four warps. Events are issued only for warps whose effect can be seen in the picks that follow. Coincident set and clear are applied to a warp that is already clear, so a wrong priority would show up as a skipped warp.

// File: rtl/wsched_pkg.sv
package wsched_pkg;
  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic advance;  // output register may take a new value this cycle
    logic grant;    // an eligible warp was found
  } schedStrobe_t;
endpackage

// File: rtl/wsched_stall_track.sv
module wsched_stall_track #(
  parameter int N     = 4,
  parameter int WID_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             setValid,
  input  logic [WID_W-1:0] setWid,
  input  logic             clrValid,
  input  logic [WID_W-1:0] clrWid,
  output logic [N-1:0]     stallBits
);
  for (genvar g = 0; g < N; g++) begin : gBit
    logic hitSet, hitClr;
    assign hitSet = setValid && (setWid == WID_W'(g));
    assign hitClr = clrValid && (clrWid == WID_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)      stallBits[g] <= 1'b0;
      else if (hitClr) stallBits[g] <= 1'b0;   // clear has priority
      else if (hitSet) stallBits[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/wsched_ctrl.sv
module wsched_ctrl
  import wsched_pkg::*;
#(
  parameter int N     = 4,
  parameter int WID_W = 2
) (
  input  logic [N-1:0]     eligible,
  input  logic [WID_W-1:0] lastWid,
  input  logic             pickValid,
  input  logic             fetchReady,
  output schedStrobe_t     strobe,
  output logic [WID_W-1:0] nextWid
);
  logic found;

  always_comb begin
    int idx;
    found   = 1'b0;
    nextWid = lastWid;
    for (int i = 1; i <= N; i++) begin
      idx = int'(lastWid) + i;
      if (idx >= N) idx = idx - N;
      if (!found && eligible[idx]) begin
        found   = 1'b1;
        nextWid = WID_W'(idx);
      end
    end
  end

  always_comb begin
    strobe.advance = !pickValid || fetchReady;
    strobe.grant   = strobe.advance && found;
  end
endmodule

// File: rtl/wsched_datapath.sv
module wsched_datapath
  import wsched_pkg::*;
#(
  parameter int N     = 4,
  parameter int WID_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  schedStrobe_t     strobe,
  input  logic [WID_W-1:0] nextWid,
  output logic             pickValid,
  output logic [WID_W-1:0] pickWid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pickValid <= 1'b0;
      pickWid   <= WID_W'(N - 1);   // so the first search begins at warp 0
    end else if (strobe.advance) begin
      pickValid <= strobe.grant;
      if (strobe.grant) pickWid <= nextWid;
    end
  end
endmodule

// File: rtl/warp_rr_sched.sv
module warp_rr_sched
  import wsched_pkg::*;
#(
  parameter int NUM_WARPS = 4,
  localparam int WID_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_WARPS-1:0] activeMask,
  input  logic                 stallSetValid,
  input  logic [WID_W-1:0]     stallSetWid,
  input  logic                 stallClrValid,
  input  logic [WID_W-1:0]     stallClrWid,
  input  logic                 fetchReady,
  output logic                 pickValid,
  output logic [WID_W-1:0]     pickWid
);
  logic [NUM_WARPS-1:0] stallBits;
  logic [NUM_WARPS-1:0] eligible;
  logic [WID_W-1:0]     nextWid;
  schedStrobe_t         strobe;

  assign eligible = activeMask & ~stallBits;

  wsched_stall_track #(.N(NUM_WARPS), .WID_W(WID_W)) u_stall (
    .clk(clk), .rst_n(rst_n),
    .setValid(stallSetValid), .setWid(stallSetWid),
    .clrValid(stallClrValid), .clrWid(stallClrWid),
    .stallBits(stallBits)
  );

  wsched_ctrl #(.N(NUM_WARPS), .WID_W(WID_W)) u_ctrl (
    .eligible(eligible), .lastWid(pickWid),
    .pickValid(pickValid), .fetchReady(fetchReady),
    .strobe(strobe), .nextWid(nextWid)
  );

  wsched_datapath #(.N(NUM_WARPS), .WID_W(WID_W)) u_dp (
    .clk(clk), .rst_n(rst_n),
    .strobe(strobe), .nextWid(nextWid),
    .pickValid(pickValid), .pickWid(pickWid)
  );
endmodule

// File: rtl/wsched_checker.sv
module wsched_checker #(
  parameter int N     = 4,
  parameter int WID_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N-1:0]     activeMask,
  input logic [N-1:0]     stallBits,
  input logic             stallSetValid,
  input logic [WID_W-1:0] stallSetWid,
  input logic             stallClrValid,
  input logic [WID_W-1:0] stallClrWid,
  input logic             fetchReady,
  input logic             pickValid,
  input logic [WID_W-1:0] pickWid
);
  logic [N-1:0] eligNow, eligPrev;
  logic advanceNow;
  assign eligNow    = activeMask & ~stallBits;
  assign advanceNow = !pickValid || fetchReady;

  always_ff @(posedge clk) eligPrev <= eligNow;

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pickValid && !fetchReady) |=> (pickValid && $stable(pickWid)));

  assert_pick_eligible_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (advanceNow && (eligNow != '0)) |=> (pickValid && eligPrev[pickWid]));

  assert_idle_keeps_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (advanceNow && (eligNow == '0)) |=> (!pickValid && $stable(pickWid)));

  assert_stall_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stallSetValid && !(stallClrValid && stallClrWid == stallSetWid))
      |=> stallBits[$past(stallSetWid)]);

  assert_stall_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stallClrValid |=> !stallBits[$past(stallClrWid)]);

  assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stallSetValid && stallClrValid && stallSetWid == stallClrWid)
      |=> !stallBits[$past(stallSetWid)]);
endmodule

bind warp_rr_sched wsched_checker #(.N(NUM_WARPS), .WID_W(WID_W)) u_wsched_checker (
  .clk(clk), .rst_n(rst_n), .activeMask(activeMask), .stallBits(stallBits),
  .stallSetValid(stallSetValid), .stallSetWid(stallSetWid),
  .stallClrValid(stallClrValid), .stallClrWid(stallClrWid),
  .fetchReady(fetchReady), .pickValid(pickValid), .pickWid(pickWid)
);

// File: tb/warp_rr_sched_bench.sv
module warp_rr_sched_bench;
  localparam int NW = 4;
  localparam int WW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NW-1:0] activeMask = '0;
  logic stallSetValid = 1'b0, stallClrValid = 1'b0, fetchReady = 1'b0;
  logic [WW-1:0] stallSetWid = '0, stallClrWid = '0;
  logic pickValid;
  logic [WW-1:0] pickWid;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  warp_rr_sched #(.NUM_WARPS(NW)) u_warp_rr_sched (
    .clk(clk), .rst_n(rst_n), .activeMask(activeMask),
    .stallSetValid(stallSetValid), .stallSetWid(stallSetWid),
    .stallClrValid(stallClrValid), .stallClrWid(stallClrWid),
    .fetchReady(fetchReady), .pickValid(pickValid), .pickWid(pickWid)
  );

  // {req, active, setV, setW, clrV, clrW, ready, expValid, expWid}
  localparam int NV = 25;
  localparam logic [17:0] VEC [NV] = '{
    {4'd1, 4'b0001, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b1, 2'd0}, // R1 first pick
    {4'd2, 4'b1111, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b1, 2'd1}, // R2
    {4'd2, 4'b1111, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b1, 2'd2},
    {4'd2, 4'b1111, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b1, 2'd3},
    {4'd2, 4'b1111, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b1, 2'd0}, // R2 wrap
    {4'd3, 4'b1010, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b1, 2'd1}, // R3
    {4'd3, 4'b1010, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b1, 2'd3}, // R3 skip inactive
    {4'd5, 4'b1010, 1'b1, 2'd1, 1'b0, 2'd0, 1'b1, 1'b1, 2'd1}, // R5 same-edge search
    {4'd5, 4'b1010, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b1, 2'd3},
    {4'd5, 4'b1010, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b1, 2'd3}, // R5 stalled skipped
    {4'd6, 4'b1010, 1'b0, 2'd0, 1'b1, 2'd1, 1'b1, 1'b1, 2'd3},
    {4'd6, 4'b1010, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b1, 2'd1}, // R6 back
    {4'd4, 4'b0000, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b0, 2'd1}, // R4 none
    {4'd4, 4'b1111, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b1, 2'd2}, // R4 resume after 1
    {4'd7, 4'b1111, 1'b1, 2'd3, 1'b1, 2'd3, 1'b1, 1'b1, 2'd3}, // R7 set+clear
    {4'd7, 4'b1111, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b1, 2'd0},
    {4'd7, 4'b1111, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b1, 2'd1},
    {4'd7, 4'b1111, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b1, 2'd2},
    {4'd7, 4'b1111, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b1, 2'd3}, // R7 warp 3 clear
    {4'd8, 4'b1111, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1, 2'd3}, // R8 hold
    {4'd8, 4'b0000, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1, 2'd3}, // R8 hold, none active
    {4'd9, 4'b1111, 1'b1, 2'd2, 1'b0, 2'd0, 1'b1, 1'b1, 2'd0}, // R9 release
    {4'd5, 4'b0100, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b0, 2'd0}, // R5 only active warp stalled
    {4'd6, 4'b0100, 1'b0, 2'd0, 1'b1, 2'd2, 1'b1, 1'b0, 2'd0}, // R6 not yet visible
    {4'd6, 4'b0100, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b1, 2'd2}  // R6 visible
  };

  task automatic check(input int req, input logic expV, input logic [WW-1:0] expW,
                       input bit careWid);
    nChecks++;
    if (pickValid !== expV || (careWid && pickWid !== expW)) begin
      nFails++;
      $display("FAIL R%0d: got valid=%0b wid=%0d, expected valid=%0b wid=%0d",
               req, pickValid, pickWid, expV, expW);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(1, 1'b0, '0, 1'b0);            // R1 reset state
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      activeMask    = VEC[v][13:10];
      stallSetValid = VEC[v][9];
      stallSetWid   = VEC[v][8:7];
      stallClrValid = VEC[v][6];
      stallClrWid   = VEC[v][5:4];
      fetchReady    = VEC[v][3];
      @(negedge clk);
      check(int'(VEC[v][17:14]), VEC[v][2], VEC[v][1:0], 1'b1);
    end

    // R1: reset clears a stall bit and restarts the search at warp 0
    activeMask = 4'b0000; stallClrValid = 1'b0;
    stallSetValid = 1'b1; stallSetWid = 2'd0;
    @(negedge clk);
    stallSetValid = 1'b0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(1, 1'b0, '0, 1'b0);
    rst_n = 1'b1; activeMask = 4'b0001; fetchReady = 1'b1;
    @(negedge clk);
    check(1, 1'b1, 2'd0, 1'b1);

    // R8: set event during hold leaves outputs fixed
    activeMask = 4'b1111; fetchReady = 1'b0;
    stallSetValid = 1'b1; stallSetWid = 2'd0;
    @(negedge clk);
    stallSetValid = 1'b0;
    check(8, 1'b1, 2'd0, 1'b1);
    fetchReady = 1'b1;
    @(negedge clk);
    check(2, 1'b1, 2'd1, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule